// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single read and write transactions against PHY management registers over the two-wire serial management interface. The host sets a 5-bit PHY address, a 5-bit register address, a read/write select and 16 bits of write data, then pulses a start strobe. The block produces the management clock by dividing the system clock, sends the frame on its data output, and controls the pad's output enable. On a read, it hands the data line over to the PHY so the PHY can return the register contents.

Every transaction takes exactly 65 management clock periods, counted as slots 0 to 64. Each period is a low half followed by a high half, and each half lasts `DIV_HALF` system clock cycles. The frame is a 32-slot preamble, then the header, then either the write payload or the read turnaround and data, and it closes with one idle slot. If the PHY does not acknowledge a read, the block still runs all 16 data slots so that every PHY on the bus stays aligned to the frame. It then reports the failure. The result is valid in the cycle that `done_o` pulses and is held until the next accepted start.

Top module: `mdio_master`

## Requirements
- R1: Slots 0 to 31 are the preamble. In these slots `mdo_o` is 1 and `mdo_oe_o` is 1.
- R2: Slots 32 to 45 carry four fields, MSB first: the start pattern 01, the opcode (10 for a read when `rd_i`=1, 01 for a write), the PHY address and the register address. `mdo_oe_o` is 1 throughout.
- R3: On a write, slots 46 and 47 carry the turnaround pattern 10 and slots 48 to 63 carry the write data, MSB first. `mdo_oe_o` stays 1 up to and including slot 63.
- R4: On a read, slot 46 is an idle slot with `mdo_o`=0 and `mdo_oe_o`=1. From slot 47 to the end of the frame, `mdo_oe_o` is 0 and `mdo_o` is 0.
- R5: On a read, `mdi_i` is sampled just before the rising edge of slot 47. A sampled 0 means the PHY acknowledged; a sampled 1 means it did not.
- R6: When a read is acknowledged, the block samples `mdi_i` before each rising edge in slots 48 to 63 and assembles `rdata_o` MSB first. `err_o` is 0.
- R7: When a read is not acknowledged, all 65 slots are still clocked. At completion `err_o`=1 and `rdata_o`=0, whatever `mdi_i` carried. A write always completes with `err_o`=0 and `rdata_o`=0.
- R8: Every transaction has exactly 65 rising edges of `mdc_o`. The last slot, slot 64, is an idle slot with `mdo_oe_o`=0.
- R9: Each half of `mdc_o` lasts `DIV_HALF` system cycles, so `busy_o` is high for exactly 130*`DIV_HALF` cycles. `mdo_o` changes only while `mdc_o` is low. While the block is idle, `mdc_o` and `mdo_oe_o` are 0.
- R10: A start strobe that arrives while `busy_o` is high has no effect. Host inputs that change during a transaction do not alter the frame being sent.
- R11: `done_o` is a one-cycle pulse in the first cycle with `busy_o` low after a transaction. After reset, `busy_o`, `done_o`, `err_o`, `mdc_o`, `mdo_oe_o` are 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| rd_i | input | 1 | 1 selects a read, 0 selects a write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid at done |
| err_o | output | 1 | No acknowledge on the last read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transaction in progress |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdo_oe_o | output | 1 | Output enable for the data pad |
| mdi_i | input | 1 | Serial data from the PHY |

## Verification
The hardest case to reach is a read where the acknowledge fails but the PHY keeps driving data bits afterwards. In that case the block must still clock all 16 data slots and discard what it sees. The bench models the PHY from the management clock edges. It drives a chosen acknowledge level in slot 47 and non-zero response data in slots 48 to 63, both in random and in directed no-acknowledge runs. A second hard case is a new start strobe, together with changed host inputs, in the middle of a frame. Directed runs raise both partway through a write and partway through a read, then compare the complete 65-slot frame against the original request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int WORD_W    = 32;
  localparam int SLOT_W    = 7;
  localparam int PRE_SLOTS = 32;
  localparam int RD_IDLE   = 46;
  localparam int ACK_SLOT  = 47;
  localparam int DAT_FIRST = 48;
  localparam int DAT_LAST  = 63;
  localparam int END_SLOT  = 64;

  typedef logic [SLOT_W-1:0] slot_t;

  function automatic logic [WORD_W-1:0] frame_word(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0] op, ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b00 : 2'b10;
    return {2'b01, op, phy, regad, ta, (rd ? '0 : wd)};
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int DIV_HALF = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == LAST)          cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  logic  tick_i,
  output logic  busy_o,
  output logic  phase_o,
  output slot_t slot_o,
  output logic  rise_o,
  output logic  fall_o,
  output logic  last_o,
  output logic  done_o
);
  logic  busy_q, phase_q, done_q;
  slot_t slot_q;

  assign rise_o = busy_q && tick_i && !phase_q;
  assign fall_o = busy_q && tick_i && phase_q;
  assign last_o = fall_o && (slot_q == slot_t'(END_SLOT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        slot_q  <= '0;
      end else if (rise_o) begin
        phase_q <= 1'b1;
      end else if (fall_o) begin
        phase_q <= 1'b0;
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = phase_q;
  assign slot_o  = slot_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mdio_shift_path.sv
module mdio_shift_path
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  slot_t             slot_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              last_i,
  input  logic              mdi_i,
  output logic              mdo_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic              rd_q, ack_q, err_q;
  logic [WORD_W-1:0] sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              in_pre, in_data;

  assign in_pre  = slot_i < slot_t'(PRE_SLOTS);
  assign in_data = (slot_i >= slot_t'(DAT_FIRST)) && (slot_i <= slot_t'(DAT_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      ack_q <= 1'b0;
      err_q <= 1'b0;
      sh_q  <= '0;
      rx_q  <= '0;
    end else if (load_i) begin
      rd_q  <= rd_i;
      ack_q <= 1'b0;
      err_q <= 1'b0;
      sh_q  <= frame_word(rd_i, phy_i, reg_i, wdata_i);
      rx_q  <= '0;
    end else begin
      if (fall_i && !in_pre) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      if (rise_i && rd_q) begin
        // high level at ack slot = no PHY response
        if (slot_i == slot_t'(ACK_SLOT)) ack_q <= mdi_i;
        if (in_data && !ack_q)           rx_q  <= {rx_q[DATA_W-2:0], mdi_i};
      end
      if (last_i) err_q <= rd_q && ack_q;
    end
  end

  assign oe_o    = busy_i && (slot_i <= (rd_q ? slot_t'(RD_IDLE) : slot_t'(DAT_LAST)));
  assign mdo_o   = oe_o && (in_pre || sh_q[WORD_W-1]);
  assign rdata_o = rx_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              mdo_oe_o,
  input  logic              mdi_i
);
  logic  accept, tick, busy, rise, fall, last;
  slot_t slot;

  assign accept = start_i && !busy;

  mdio_tick_gen #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .run_i   (busy),
    .tick_o  (tick)
  );

  mdio_frame_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .tick_i   (tick),
    .busy_o   (busy),
    .phase_o  (mdc_o),
    .slot_o   (slot),
    .rise_o   (rise),
    .fall_o   (fall),
    .last_o   (last),
    .done_o   (done_o)
  );

  mdio_shift_path u_path (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .rd_i    (rd_i),
    .phy_i   (phy_addr_i),
    .reg_i   (reg_addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .slot_i  (slot),
    .rise_i  (rise),
    .fall_i  (fall),
    .last_i  (last),
    .mdi_i   (mdi_i),
    .mdo_o   (mdo_o),
    .oe_o    (mdo_oe_o),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o,
  input logic        mdc_o,
  input logic        mdo_o,
  input logic        mdo_oe_o
);
  // R9
  mdo_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdo_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdo_oe_o));

  // R11
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  start_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R7
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == 16'h0));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .rdata_o  (rdata_o),
  .mdc_o    (mdc_o),
  .mdo_o    (mdo_o),
  .mdo_oe_o (mdo_oe_o)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int DIV = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        err_o, done_o, busy_o, mdc_o, mdo_o, mdo_oe_o;
  logic        mdi_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;
  logic        obs_mdo [0:69];
  logic        obs_oe  [0:69];
  logic        phy_ack = 1'b1;
  logic [15:0] phy_rsp = '0;

  always #2.5 clk_i = ~clk_i;

  mdio_master #(.DIV_HALF(DIV)) u_dut (
    .clk_i, .rst_ni, .start_i, .rd_i, .phy_addr_i, .reg_addr_i, .wdata_i,
    .rdata_o, .err_o, .done_o, .busy_o, .mdc_o, .mdo_o, .mdo_oe_o, .mdi_i
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_oe(input logic rd, input int s);
    if (s <= 46) return 1'b1;
    return rd ? 1'b0 : (s <= 63);
  endfunction

  function automatic logic exp_mdo(input logic rd, input logic [4:0] p, input logic [4:0] r,
                                   input logic [15:0] wd, input int s);
    logic [31:0] w;
    w = {2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
    if (s < 32) return 1'b1;
    if (!exp_oe(rd, s)) return 1'b0;
    return w[31-(s-32)];
  endfunction

  // record line state at each management clock rise
  initial forever begin
    @(posedge mdc_o);
    #1;
    if (rise_cnt < 70) begin
      obs_mdo[rise_cnt] = mdo_o;
      obs_oe[rise_cnt]  = mdo_oe_o;
    end
    rise_cnt++;
  end

  // PHY model: drive response while clock low
  initial forever begin
    @(negedge mdc_o);
    #1;
    if (rise_cnt == 47)                      mdi_i = ~phy_ack;
    else if (rise_cnt >= 48 && rise_cnt <= 63) mdi_i = phy_rsp[63-rise_cnt];
    else                                     mdi_i = 1'b1;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run_txn(input logic rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] wd, input logic ack, input logic [15:0] rsp,
                         input bit inject);
    int cyc;
    bit pre_ok, hdr_ok, body_ok, oe_ok;
    logic [15:0] exp_rd;
    phy_ack = ack;
    phy_rsp = rsp;
    rise_cnt = 0;
    mdi_i = 1'b1;
    @(negedge clk_i);
    rd_i = rd; phy_addr_i = p; reg_addr_i = r; wdata_i = wd; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 5000) begin
      cyc++;
      if (inject && cyc == 40) begin
        start_i = 1'b1; rd_i = ~rd; phy_addr_i = ~p; reg_addr_i = ~r; wdata_i = ~wd;
      end
      if (inject && cyc == 41) start_i = 1'b0;
      @(negedge clk_i);
    end
    // R9 busy length, R11 done pulse
    check(cyc == 130*DIV, "R9 busy length", cyc, 130*DIV);
    check(done_o == 1'b1, "R11 done at end", done_o, 1);
    check(rise_cnt == 65, "R8 mdc rise count", rise_cnt, 65);
    pre_ok = 1; hdr_ok = 1; body_ok = 1; oe_ok = 1;
    for (int s = 0; s < 65; s++) begin
      if (obs_oe[s] !== exp_oe(rd, s)) oe_ok = 0;
      if (obs_mdo[s] !== exp_mdo(rd, p, r, wd, s)) begin
        if (s < 32) pre_ok = 0;
        else if (s <= 45) hdr_ok = 0;
        else body_ok = 0;
      end
    end
    check(pre_ok, "R1 preamble", pre_ok, 1);
    check(hdr_ok, inject ? "R10 R2 header after ignored start" : "R2 header", hdr_ok, 1);
    check(body_ok, rd ? "R4 read idle/release" : "R3 write payload", body_ok, 1);
    check(oe_ok, rd ? "R4 read oe pattern" : "R3 write oe pattern", oe_ok, 1);
    check(obs_oe[64] == 1'b0, "R8 trailing idle oe", obs_oe[64], 0);
    exp_rd = (rd && ack) ? rsp : 16'h0;
    check(rdata_o == exp_rd, ack ? "R6 read data" : "R7 read data zero", rdata_o, exp_rd);
    check(err_o == (rd && !ack), rd ? "R5 ack/err flag" : "R7 write err", err_o, rd && !ack);
    @(negedge clk_i);
    check(done_o == 1'b0 && !busy_o, "R11 done single cycle", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    #12;
    check(busy_o == 0 && done_o == 0 && err_o == 0 && mdc_o == 0 && mdo_oe_o == 0 && rdata_o == 0,
          "R11 reset state", {busy_o, done_o, err_o, mdc_o, mdo_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(mdc_o == 0 && mdo_oe_o == 0, "R9 idle lines", {mdc_o, mdo_oe_o}, 0);
    run_txn(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1'b1, 16'h0000, 0);
    run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'h0000, 0);
    run_txn(1'b1, 5'h01, 5'h02, 16'h0000, 1'b1, 16'h8001, 0);
    run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b0, 16'hFFFF, 0);
    run_txn(1'b0, 5'h0A, 5'h15, 16'hA5C3, 1'b1, 16'h0000, 1);
    run_txn(1'b1, 5'h03, 5'h11, 16'h0000, 1'b1, 16'h3C5A, 1);
    run_txn(1'b1, 5'h07, 5'h04, 16'h0000, 1'b0, 16'h1234, 1);
    for (int i = 0; i < 14; i++) begin
      logic [15:0] rsp;
      rsp = 16'($urandom);
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              ($urandom % 4) != 0, rsp, ($urandom % 3) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule